// File: doc/BRIEF.md
# Three-Channel Shared-Period PWM Timer

This block is an up-counting timer that drives up to three pulse-width modulated pins. All three pins share one cycle length, set by a period register. Each pin has its own duty-compare register that sets where its active phase begins. Each pin can be enabled separately and has its own polarity and start-up level. The counter advances on ticks from a count source. That source is either an internal clock-enable strobe or an external pin, sampled through a synchroniser, with a selectable active edge.

Software reaches the block through a single write port. An address selects the period, one of the three duties, the counter itself, the configuration word, the start control or the cutoff-clear control. Counting either runs freely until software stops it, or halts by itself at the first period match. A cutoff input forces every enabled pin to its inactive level in the same cycle. The pins stay there until the input has gone low and software clears the latched cutoff state.

Top module: `pwm3_timer`

Register map (`wr_addr`): 0 period, 1/2/3 duty of pin 0/1/2, 4 counter, 5 configuration, 6 start control (bit 0: 1 start, 0 stop), 7 cutoff clear (bit 0). The configuration word uses these fields:
- bits [2:0]: pin enable.
- bits [5:3]: polarity, where 1 means active-high.
- bits [8:6]: level loaded at start.
- bit 9: stop mode, where 1 means manual stop and 0 means stop at the period match.

## Requirements
- R1: The counter changes only on a tick of the selected source while running, rising by one per tick.
- R2: With period value m, the tick after the counter equals m sets it to 0, so one cycle lasts m+1 ticks.
- R3: For duty value n < m an enabled pin is inactive for n+1 ticks and active for m−n ticks per cycle. If n ≥ m the pin stays inactive, because the period match wins over a duty match.
- R4: Polarity is per pin: polarity bit 1 makes the active level high, 0 makes it low.
- R5: Each pin is enabled on its own; several may run at once with different duties, and a disabled pin drives 0.
- R6: Writing 1 to the start control while stopped loads each pin with its configured start level.
- R7: With stop mode 1, writing 0 to the start control halts the counter, and the pins and counter hold their values.
- R8: With stop mode 0, counting halts at the period match: the counter stays at m and the pins are inactive. Writing 0 to the start control in this mode has no effect.
- R9: `irq_cmp` pulses for one cycle after each tick on which the counter equals the period value or the duty value of an enabled pin.
- R10: `irq_ovf` pulses for one cycle when a tick takes the counter from all ones to 0, and the counter then reads 0.
- R11: A write to the counter address replaces the counter value, visible on `count` the next cycle.
- R12: While `cut_in` is high, every enabled pin shows its inactive level in the same cycle. The pins stay inactive after `cut_in` falls, until a 1 is written to bit 0 of the cutoff-clear address.
- R13: With the external source selected, edge mode 0 counts rising edges, 1 counts falling edges and 2 counts both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Internal count-source strobe |
| ext_clk_pin | input | 1 | External count-source pin (asynchronous) |
| src_ext | input | 1 | 1 selects the external pin as count source |
| edge_mode | input | 2 | External edge: 0 rising, 1 falling, 2 both |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| cut_in | input | 1 | Forced cutoff request |
| count | output | W | Counter readback |
| irq_cmp | output | 1 | Compare-match pulse |
| irq_ovf | output | 1 | Counter overflow pulse |
| pwm_out | output | 3 | PWM pins |

## Verification
A corrupted counter shows on `count` within one tick. It also moves the duty edges, so the high count of a pin measured over two whole cycles drifts from 2·(m−n) within that window. A wrong run state appears as a counter that moves or freezes against the stop mode within one tick. A lost cutoff latch is seen the first cycle after `cut_in` falls, as a pin leaving its inactive level before the clear write.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
   localparam int NCH     = 3;
   localparam int CFG_W   = 10;

   typedef enum logic [2:0] {
      A_PERIOD = 3'd0,
      A_DUTY0  = 3'd1,
      A_DUTY1  = 3'd2,
      A_DUTY2  = 3'd3,
      A_COUNT  = 3'd4,
      A_CONFIG = 3'd5,
      A_START  = 3'd6,
      A_CLEAR  = 3'd7
   } reg_addr_e;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_NONE = 2'd3
   } edge_mode_e;

   typedef struct packed {
      logic             manual_stop;
      logic [NCH-1:0]   start_lvl;
      logic [NCH-1:0]   act_high;
      logic [NCH-1:0]   out_en;
   } cfg_t;
endpackage

// File: rtl/pwm3_tick_sel.sv
module pwm3_tick_sel #(
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_SRC_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       int_en,
   input  logic       ext_pin,
   input  logic       src_ext,
   input  logic [1:0] edge_mode,
   output logic       tick
);
   import pwm3_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pwm3_tick_sel: SYNC_STAGES must be at least 2");
   end

   if (EXT_SRC_EN) begin : g_ext
      localparam int SH_W = SYNC_STAGES + 1;
      logic [SH_W-1:0] sh_q;
      logic            now_lvl, old_lvl, ext_tick;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[SH_W-2:0], ext_pin};
      end

      assign now_lvl = sh_q[SYNC_STAGES-1];
      assign old_lvl = sh_q[SYNC_STAGES];

      always_comb begin
         case (edge_mode_e'(edge_mode))
            EDGE_RISE: ext_tick = now_lvl & ~old_lvl;
            EDGE_FALL: ext_tick = ~now_lvl & old_lvl;
            EDGE_BOTH: ext_tick = now_lvl ^ old_lvl;
            default:   ext_tick = 1'b0;
         endcase
      end

      assign tick = src_ext ? ext_tick : int_en;
   end else begin : g_int
      assign tick = int_en;
   end
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         start_wr,
   input  logic         start_val,
   input  logic         manual_stop,
   input  logic         cnt_wr,
   input  logic [W-1:0] cnt_wdata,
   input  logic [W-1:0] period,
   output logic [W-1:0] cnt,
   output logic         running,
   output logic         step,
   output logic         per_hit,
   output logic         ovf
);
   localparam logic [W-1:0] CNT_MAX = '1;

   logic [W-1:0] cnt_q;
   logic         run_q;

   assign step    = run_q & tick & ~cnt_wr;
   assign per_hit = (cnt_q == period);
   assign ovf     = step & ~per_hit & (cnt_q == CNT_MAX);
   assign cnt     = cnt_q;
   assign running = run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= cnt_wdata;
      end else if (step) begin
         if (per_hit) cnt_q <= manual_stop ? '0 : cnt_q;
         else         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (start_wr) begin
         if (start_val)        run_q <= 1'b1;
         else if (manual_stop) run_q <= 1'b0;
      end else if (step && per_hit && !manual_stop) begin
         run_q <= 1'b0;
      end
   end

   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !cnt_wr) |=> $stable(cnt_q));

   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && per_hit && manual_stop) |=> (cnt_q == '0));

   // R8
   oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && per_hit && !manual_stop && !start_wr) |=> (!run_q && $stable(cnt_q)));
endmodule

// File: rtl/pwm3_channel.sv
module pwm3_channel #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] duty,
   input  logic         step,
   input  logic         per_hit,
   input  logic         load,
   input  logic         en,
   input  logic         act_high,
   input  logic         start_lvl,
   input  logic         cut,
   output logic         duty_hit,
   output logic         pin
);
   logic lvl_q;

   assign duty_hit = (cnt == duty);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
      end else if (load) begin
         lvl_q <= start_lvl;
      end else if (step) begin
         if (per_hit)       lvl_q <= ~act_high;
         else if (duty_hit) lvl_q <= act_high;
      end
   end

   always_comb begin
      if (!en)     pin = 1'b0;
      else if (cut) pin = ~act_high;
      else          pin = lvl_q;
   end

   // R3
   period_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && per_hit && !load) |=> (lvl_q == ~$past(act_high)));

   // R3
   duty_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !per_hit && duty_hit && !load) |=> (lvl_q == $past(act_high)));
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer #(
   parameter int W           = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_SRC_EN  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_en,
   input  logic         ext_clk_pin,
   input  logic         src_ext,
   input  logic [1:0]   edge_mode,
   input  logic         wr_en,
   input  logic [2:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   input  logic         cut_in,
   output logic [W-1:0] count,
   output logic         irq_cmp,
   output logic         irq_ovf,
   output logic [2:0]   pwm_out
);
   import pwm3_pkg::*;

   if (W < CFG_W) begin : g_bad_width
      $error("pwm3_timer: W must hold the configuration word");
   end

   logic [W-1:0]   period_q;
   logic [W-1:0]   duty_q [NCH];
   cfg_t           cfg_q;
   logic           cut_q, cut_any;
   logic           tick, step, per_hit, ovf, running;
   logic           start_wr, cnt_wr, clr_wr, load;
   logic [NCH-1:0] duty_hit;
   logic [W-1:0]   cnt;

   assign start_wr = wr_en && (reg_addr_e'(wr_addr) == A_START);
   assign cnt_wr   = wr_en && (reg_addr_e'(wr_addr) == A_COUNT);
   assign clr_wr   = wr_en && (reg_addr_e'(wr_addr) == A_CLEAR) && wr_data[0];
   assign load     = start_wr && wr_data[0] && !running;
   assign cut_any  = cut_in | cut_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         cfg_q    <= '0;
      end else if (wr_en) begin
         if (reg_addr_e'(wr_addr) == A_PERIOD) period_q <= wr_data;
         if (reg_addr_e'(wr_addr) == A_CONFIG) cfg_q    <= cfg_t'(wr_data[CFG_W-1:0]);
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_duty
      localparam logic [2:0] MY_ADDR = 3'(A_DUTY0) + 3'(i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             duty_q[i] <= '1;
         else if (wr_en && wr_addr == MY_ADDR)   duty_q[i] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cut_q <= 1'b0;
      else if (cut_in) cut_q <= 1'b1;
      else if (clr_wr) cut_q <= 1'b0;
   end

   pwm3_tick_sel #(.SYNC_STAGES(SYNC_STAGES), .EXT_SRC_EN(EXT_SRC_EN)) u_tick (
      .clk(clk), .rst_n(rst_n), .int_en(cnt_en), .ext_pin(ext_clk_pin),
      .src_ext(src_ext), .edge_mode(edge_mode), .tick(tick)
   );

   pwm3_counter #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_wr(start_wr),
      .start_val(wr_data[0]), .manual_stop(cfg_q.manual_stop), .cnt_wr(cnt_wr),
      .cnt_wdata(wr_data), .period(period_q), .cnt(cnt), .running(running),
      .step(step), .per_hit(per_hit), .ovf(ovf)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      pwm3_channel #(.W(W)) u_ch (
         .clk(clk), .rst_n(rst_n), .cnt(cnt), .duty(duty_q[i]), .step(step),
         .per_hit(per_hit), .load(load), .en(cfg_q.out_en[i]),
         .act_high(cfg_q.act_high[i]), .start_lvl(cfg_q.start_lvl[i]),
         .cut(cut_any), .duty_hit(duty_hit[i]), .pin(pwm_out[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_cmp <= 1'b0;
         irq_ovf <= 1'b0;
      end else begin
         irq_cmp <= step && (per_hit || |(duty_hit & cfg_q.out_en));
         irq_ovf <= ovf;
      end
   end

   assign count = cnt;

   // R10
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |-> (count == '0));

   // R12
   cut_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cut_in |=> cut_q);

   // R9
   cmp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cmp |-> $past(running));
endmodule

// File: tb/pwm3_timer_bench.sv
module pwm3_timer_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cnt_en = 1'b0;
   logic         ext_clk_pin = 1'b0;
   logic         src_ext = 1'b0;
   logic [1:0]   edge_mode = 2'd0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_addr = 3'd0;
   logic [W-1:0] wr_data = '0;
   logic         cut_in = 1'b0;
   logic [W-1:0] count;
   logic         irq_cmp, irq_ovf;
   logic [2:0]   pwm_out;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   pwm3_timer #(.W(W)) u_pwm3_timer (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ext_clk_pin(ext_clk_pin),
      .src_ext(src_ext), .edge_mode(edge_mode), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cut_in(cut_in), .count(count), .irq_cmp(irq_cmp),
      .irq_ovf(irq_ovf), .pwm_out(pwm_out)
   );

   // period m, duty n, expected active ticks per cycle
   localparam int NVEC = 8;
   localparam int VEC [NVEC][3] = '{
      '{9, 3, 6}, '{9, 0, 9}, '{9, 8, 1}, '{9, 9, 0},
      '{9, 12, 0}, '{4, 1, 3}, '{15, 7, 8}, '{1, 0, 1}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(addr); wr_data = W'(data);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // count samples of pin ch at level lvl over n negedges
   task automatic count_lvl(input int ch, input bit lvl, input int n, output int hits);
      hits = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (pwm_out[ch] == lvl) hits++;
      end
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      cnt_en = 1'b1;
      for (int k = 0; k < n; k++) @(negedge clk);
      cnt_en = 1'b0;
   endtask

   task automatic ext_pulses(input int n);
      for (int k = 0; k < n; k++) begin
         ext_clk_pin = 1'b1; idle(4);
         ext_clk_pin = 1'b0; idle(4);
      end
      idle(4);
   endtask

   task automatic restart(input int cfg);
      wr(5, 32'h200);   // manual stop mode so that stop is honoured
      wr(6, 0);
      wr(4, 0);
      wr(5, cfg);
   endtask

   initial begin
      int h, h2, snap_cnt, snap_pin, bad;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R1 reset count", int'(count), 0);
      check("R5 reset pins", int'(pwm_out), 0);
      check("R9 reset irq", int'({irq_cmp, irq_ovf}), 0);

      // table walk: R3 duty/period shapes, pin 0 active-high, manual stop
      for (int v = 0; v < NVEC; v++) begin
         restart(32'h209);
         wr(0, VEC[v][0]);
         wr(1, VEC[v][1]);
         cnt_en = 1'b1;
         wr(6, 1);
         idle(VEC[v][0] + 3);
         count_lvl(0, 1'b1, 2 * (VEC[v][0] + 1), h);
         check($sformatf("R3 vec%0d active ticks", v), h, 2 * VEC[v][2]);
         cnt_en = 1'b0;
      end

      // R1: no tick, no movement; three ticks give three
      restart(32'h209);
      wr(0, 9);
      wr(6, 1);
      idle(5);
      check("R1 stable without tick", int'(count), 0);
      ticks(3);
      check("R1 three ticks", int'(count), 3);

      // R2: period 5, eight ticks wrap to 2
      restart(32'h209);
      wr(0, 5);
      wr(6, 1);
      ticks(8);
      check("R2 wrap after m+1", int'(count), 2);

      // R4: pin 1 active-low, duty 3 period 9
      restart(32'h202);
      wr(0, 9); wr(2, 3);
      cnt_en = 1'b1; wr(6, 1);
      idle(12);
      count_lvl(1, 1'b0, 20, h);
      check("R4 active-low width", h, 12);
      cnt_en = 1'b0;

      // R5: pins 0 and 2 at different duties, pin 1 disabled
      restart(32'h22D);
      wr(0, 9); wr(1, 2); wr(3, 6);
      cnt_en = 1'b1; wr(6, 1);
      idle(12);
      h = 0; h2 = 0; bad = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (pwm_out[0]) h++;
         if (pwm_out[2]) h2++;
         if (pwm_out[1]) bad++;
      end
      cnt_en = 1'b0;
      check("R5 pin0 high", h, 14);
      check("R5 pin2 high", h2, 6);
      check("R5 disabled pin stays 0", bad, 0);

      // R6: start level loaded on start
      restart(32'h249);
      wr(6, 1);
      check("R6 start level 1", int'(pwm_out[0]), 1);
      restart(32'h209);
      wr(6, 1);
      check("R6 start level 0", int'(pwm_out[0]), 0);

      // R7: manual stop holds count and pin
      restart(32'h209);
      wr(0, 9); wr(1, 3);
      cnt_en = 1'b1; wr(6, 1);
      idle(7);
      wr(6, 0);
      snap_cnt = int'(count); snap_pin = int'(pwm_out[0]);
      idle(10);
      check("R7 count held", int'(count), snap_cnt);
      check("R7 pin held", int'(pwm_out[0]), snap_pin);
      cnt_en = 1'b0;

      // R8: one-shot stop at period match
      restart(32'h009);
      wr(0, 5); wr(1, 2);
      cnt_en = 1'b1; wr(6, 1);
      idle(20);
      check("R8 count halted at m", int'(count), 5);
      check("R8 pin inactive", int'(pwm_out[0]), 0);
      cnt_en = 1'b0;
      wr(4, 0);
      wr(6, 1);
      wr(6, 0);       // ignored in this mode
      ticks(2);
      check("R8 stop write ignored", int'(count), 2);

      // R9: compare pulses, pin 1 disabled duty excluded
      restart(32'h209);
      wr(0, 9); wr(1, 3); wr(2, 5);
      wr(6, 1);
      h = 0;
      @(negedge clk);
      cnt_en = 1'b1;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (irq_cmp) h++;
      end
      cnt_en = 1'b0;
      @(negedge clk);
      if (irq_cmp) h++;
      check("R9 compare pulses", h, 4);

      // R10/R11: overflow from all ones
      restart(32'h209);
      wr(0, 9); wr(1, 3);
      wr(4, 32'hFFFE);
      check("R11 counter write", int'(count), 32'hFFFE);
      wr(6, 1);
      ticks(1);
      check("R10 no ovf before wrap", int'(irq_ovf), 0);
      @(negedge clk);
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
      check("R10 ovf pulse", int'(irq_ovf), 1);
      check("R10 count after wrap", int'(count), 0);
      @(negedge clk);
      check("R10 ovf one cycle", int'(irq_ovf), 0);
      wr(4, 7);
      check("R11 write while running", int'(count), 7);

      // R12: cutoff, pin 1 active-low so its inactive level is 1
      restart(32'h20B);
      wr(0, 9); wr(1, 3); wr(2, 5);
      cnt_en = 1'b1; wr(6, 1);
      idle(4);
      #2 cut_in = 1'b1;
      #1 check("R12 immediate cutoff", int'(pwm_out), 2);
      @(negedge clk);
      cut_in = 1'b0;
      bad = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (pwm_out != 3'b010) bad++;
      end
      check("R12 cutoff latched", bad, 0);
      wr(7, 1);
      idle(2);
      count_lvl(0, 1'b1, 20, h);
      check("R12 resumes after clear", h, 12);
      cnt_en = 1'b0;

      // R13: external source edges
      restart(32'h209);
      wr(0, 32'h00FF);
      src_ext = 1'b1;
      edge_mode = 2'd0;
      wr(6, 1);
      ext_pulses(4);
      check("R13 rising edges", int'(count), 4);
      wr(4, 0);
      edge_mode = 2'd1;
      ext_pulses(4);
      check("R13 falling edges", int'(count), 4);
      wr(4, 0);
      edge_mode = 2'd2;
      ext_pulses(4);
      check("R13 both edges", int'(count), 8);
      src_ext = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_500_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule